// File: doc/BRIEF.md
# Codec Control Register File with Indexed Window

This block is the control-register front end of an audio codec. It sits on a plain word-addressed bus with a read strobe, a write strobe, a byte address and 32-bit data. It decodes a word slot from the byte address and serves a bank of sixteen 32-bit direct slots. It also holds a second bank of thirty-two 8-bit entries that are reached only through an index pointer.

The pointer is the low five bits of direct slot 0. Direct slot 1 is a window: a bus access there reaches the indexed entry instead of a direct register. Some entries follow special access rules. One is hidden from reads. Two refuse writes. One merges a single writable bit with a fixed codec identifier.

A write to the control slot with its lowest bit set returns every register to its power-on value. The control slot itself still records the written value.

Top module: `codec_regfile`

## Requirements
- R1: After a hardware reset, every direct slot reads 0. Every indexed entry reads 0, except entry 12, which reads 0x8A, and entry 25, which reads 0xA0.
- R2: The word slot is address bits [5:2]. Address bits [1:0] and all address bits above bit 5 have no effect on which register is reached.
- R3: The index is bits [4:0] of direct slot 0. A write to slot 1 stores wdata[7:0] into the indexed entry. A read of slot 1 returns that entry zero-extended to 32 bits.
- R4: Indexed entry 3 accepts writes but always reads back as 0.
- R5: Writes to indexed entries 11 and 25 are ignored. They keep reading 0x00 and 0xA0.
- R6: A write to indexed entry 12 stores (wdata & 0x40) | 0x8A.
- R7: Direct slot 2 always reads 0, and writes to it are ignored.
- R8: A write to direct slot 4 stores wdata[6:0]. Bits [31:7] read as 0.
- R9: A write to slot 4 with wdata[0] = 1 puts every other direct slot and every indexed entry back to its R1 value, including the index in slot 0. In the same cycle, slot 4 takes the masked value from R8.
- R10: Direct slots 0, 3 and 5 to 15 store the full 32-bit write data.
- R11: Read data appears in the same cycle as rd_en and shows the state before any write on that clock edge. A write takes effect at the rising edge where wr_en is high. rdata is 0 while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W (8) | Byte address |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, combinational |

## Verification
The bench uses the default parameters, which gives an 8-bit address. The two bits above the 6-bit register space are real bus inputs, so random upper bits and random byte-lane bits show whether register aliases land on the right slot. A fixed set of sixteen direct slots and thirty-two entries lets the bench model mirror every register, so every random read can be checked against its exact expected value. Those random reads include the special entries and the reset path triggered by the control slot.

// File: rtl/codec_reg_pkg.sv
package codec_reg_pkg;
  // Direct slots with special behaviour
  localparam int unsigned SLOT_INDEX  = 0;
  localparam int unsigned SLOT_WINDOW = 1;
  localparam int unsigned SLOT_RO     = 2;
  localparam int unsigned SLOT_CTRL   = 4;
  localparam int unsigned CTRL_BITS   = 7;

  // Indexed entries with special behaviour
  localparam int unsigned ENT_HIDDEN  = 3;
  localparam int unsigned ENT_LOCKED  = 11;
  localparam int unsigned ENT_MERGE   = 12;
  localparam int unsigned ENT_CHIPID  = 25;

  localparam logic [7:0] CODEC_ID   = 8'h8A;
  localparam logic [7:0] CHIP_ID    = 8'hA0;
  localparam logic [7:0] MERGE_KEEP = 8'h40;

  function automatic logic [7:0] ind_reset_value(int unsigned e);
    case (e)
      ENT_MERGE:  return CODEC_ID;
      ENT_CHIPID: return CHIP_ID;
      default:    return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/codec_reset_sync.sv
module codec_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_no = sh_q[STAGES-1];
endmodule

// File: rtl/codec_direct_bank.sv
module codec_direct_bank
  import codec_reg_pkg::*;
#(
  parameter int unsigned N      = 16,
  parameter int unsigned W      = 32,
  parameter int unsigned SLOT_W = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SLOT_W-1:0]   wr_slot,
  input  logic [W-1:0]        wdata,
  input  logic                soft_rst,
  output logic [N-1:0][W-1:0] regs_o
);
  localparam logic [W-1:0] CTRL_MASK = W'((1 << CTRL_BITS) - 1);

  for (genvar s = 0; s < N; s++) begin : g_slot
    if (s == SLOT_WINDOW || s == SLOT_RO) begin : g_none
      assign regs_o[s] = '0;
    end else begin : g_store
      logic [W-1:0] q;
      logic [W-1:0] d;
      logic         en;
      logic         hit;

      assign hit = wr_en && (wr_slot == SLOT_W'(s));
      assign en  = soft_rst || hit;

      always_comb begin
        d = q;
        if (s == SLOT_CTRL) begin
          if (hit) d = wdata & CTRL_MASK;
        end else if (soft_rst) begin
          d = '0;
        end else if (hit) begin
          d = wdata;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= d;
      end

      assign regs_o[s] = q;
    end
  end

  // The control slot holds only its masked bits after a write.
  assert_ctrl_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_slot == SLOT_W'(SLOT_CTRL)) |=> (regs_o[SLOT_CTRL] == ($past(wdata) & CTRL_MASK)));

  // A soft reset clears the index pointer.
  assert_soft_clears_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (regs_o[SLOT_INDEX] == '0));

  // A plain slot stores the whole word.
  assert_full_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_slot == SLOT_W'(3) && !soft_rst) |=> (regs_o[3] == $past(wdata)));
endmodule

// File: rtl/codec_indirect_bank.sv
module codec_indirect_bank
  import codec_reg_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned W       = 8,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wdata,
  input  logic             soft_rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     rd_data
);
  logic [ENTRIES-1:0][W-1:0] ent;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    if (e == ENT_LOCKED || e == ENT_CHIPID) begin : g_const
      assign ent[e] = W'(ind_reset_value(e));
    end else begin : g_store
      localparam logic [W-1:0] RST_VAL = W'(ind_reset_value(e));
      logic [W-1:0] q;
      logic [W-1:0] d;
      logic         en;
      logic         hit;

      assign hit = wr_en && (wr_idx == IDX_W'(e));
      assign en  = soft_rst || hit;

      always_comb begin
        d = q;
        if (soft_rst)              d = RST_VAL;
        else if (e == ENT_MERGE)   d = (wdata & W'(MERGE_KEEP)) | W'(CODEC_ID);
        else                       d = wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= RST_VAL;
        else if (en) q <= d;
      end

      assign ent[e] = q;
    end
  end

  always_comb begin
    if (rd_idx == IDX_W'(ENT_HIDDEN)) rd_data = '0;
    else                              rd_data = ent[rd_idx];
  end

  // Entry 12 always carries the codec identifier in its fixed bits.
  assert_merge_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ent[ENT_MERGE] & ~W'(MERGE_KEEP)) == W'(CODEC_ID)));
endmodule

// File: rtl/codec_regfile.sv
module codec_regfile
  import codec_reg_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned DIRECT_WORDS = 16,
  parameter int unsigned IND_ENTRIES  = 32,
  parameter int unsigned IND_W        = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned SLOT_W = $clog2(DIRECT_WORDS);
  localparam int unsigned IDX_W  = $clog2(IND_ENTRIES);
  localparam int unsigned SLOT_HI = SLOT_W + 1;

  logic                             rst_n;
  logic [SLOT_W-1:0]                slot;
  logic [IDX_W-1:0]                 idx;
  logic [DIRECT_WORDS-1:0][DATA_W-1:0] dregs;
  logic [IND_W-1:0]                 ind_rd;
  logic                             soft_rst;
  logic                             win_wr;
  logic                             unused_addr;

  codec_reset_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  assign slot = addr[SLOT_HI:2];

  if (ADDR_W > SLOT_HI + 1) begin : g_upper
    assign unused_addr = ^{addr[ADDR_W-1:SLOT_HI+1], addr[1:0]};
  end else begin : g_no_upper
    assign unused_addr = ^addr[1:0];
  end

  assign idx      = dregs[SLOT_INDEX][IDX_W-1:0];
  assign soft_rst = wr_en && (slot == SLOT_W'(SLOT_CTRL)) && wdata[0];
  assign win_wr   = wr_en && (slot == SLOT_W'(SLOT_WINDOW));

  codec_direct_bank #(.N(DIRECT_WORDS), .W(DATA_W)) u_direct (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_slot  (slot),
    .wdata    (wdata),
    .soft_rst (soft_rst),
    .regs_o   (dregs)
  );

  codec_indirect_bank #(.ENTRIES(IND_ENTRIES), .W(IND_W)) u_indirect (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (win_wr),
    .wr_idx   (idx),
    .wdata    (wdata[IND_W-1:0]),
    .soft_rst (soft_rst),
    .rd_idx   (idx),
    .rd_data  (ind_rd)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (slot == SLOT_W'(SLOT_WINDOW)) rdata = DATA_W'(ind_rd);
      else                              rdata = dregs[slot];
    end
  end

  assert_hidden_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && slot == SLOT_W'(SLOT_WINDOW) && idx == IDX_W'(ENT_HIDDEN)) |-> (rdata == '0));

  assert_chip_id_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && slot == SLOT_W'(SLOT_WINDOW) && idx == IDX_W'(ENT_CHIPID)) |-> (rdata == DATA_W'(CHIP_ID)));

  assert_ro_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && slot == SLOT_W'(SLOT_RO)) |-> (rdata == '0));

  assert_idle_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0));
endmodule

// File: tb/sim_codec_regfile.sv
`timescale 1ns/1ps
module sim_codec_regfile;
  logic        clk;
  logic        rst_ni;
  logic        rd_en;
  logic        wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;

  int checks;
  int fails;
  bit done;

  logic [31:0] dm [16];
  logic [7:0]  im [32];

  codec_regfile u0 (
    .clk(clk), .rst_ni(rst_ni), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic report();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=finished");
      report();
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) dm[i] = 32'h0;
    for (int i = 0; i < 32; i++) im[i] = 8'h00;
    im[12] = 8'h8A;
    im[25] = 8'hA0;
  endtask

  task automatic model_write(logic [7:0] a, logic [31:0] d);
    int s;
    int ix;
    s  = int'(a[5:2]);
    ix = int'(dm[0][4:0]);
    case (s)
      1: begin
        if (ix == 12)                 im[ix] = (d[7:0] & 8'h40) | 8'h8A;
        else if (ix != 11 && ix != 25) im[ix] = d[7:0];
      end
      2: ;
      4: begin
        if (d[0]) model_reset();
        dm[4] = d & 32'h7F;
      end
      default: dm[s] = d;
    endcase
  endtask

  function automatic logic [31:0] exp_read(logic [7:0] a);
    int s;
    int ix;
    s  = int'(a[5:2]);
    ix = int'(dm[0][4:0]);
    if (s == 1) return (ix == 3) ? 32'h0 : {24'h0, im[ix]};
    return dm[s];
  endfunction

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    model_write(a, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(string req, logic [7:0] a);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1;
    check(req, rdata, exp_read(a));
    rd_en = 1'b0;
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_reset_state(string req);
    for (int s = 0; s < 16; s++) bus_read(req, 8'(s * 4));
    for (int e = 0; e < 32; e++) begin
      bus_write(8'h00, 32'(e));
      bus_read(req, 8'h04);
    end
  endtask

  initial begin
    void'($urandom(32'h00C0DEC5));
    checks = 0; fails = 0; done = 0;
    rd_en = 0; wr_en = 0; addr = 0; wdata = 0; rst_ni = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    check_reset_state("R1");
    @(negedge clk); #1 check("R11 idle", rdata, 32'h0);

    // R2 aliases through byte-lane and upper address bits
    bus_write(8'hD7, 32'hCAFEF00D);
    bus_read("R2", 8'h14);
    bus_read("R2", 8'h56);
    bus_read("R2", 8'h95);

    // R3 index from low bits of slot 0, byte stored, zero-extended
    bus_write(8'h00, 32'hFFFF_FFE7);
    bus_write(8'h04, 32'h1234_5678);
    bus_read("R3", 8'h04);
    check("R3 value", exp_read(8'h04), 32'h78);
    bus_write(8'h00, 32'h0000_0008);
    bus_read("R3 other entry", 8'h04);

    // R4 hidden entry
    bus_write(8'h00, 32'd3);
    bus_write(8'h04, 32'h55);
    bus_read("R4", 8'h04);

    // R5 locked entries
    bus_write(8'h00, 32'd11);
    bus_write(8'h04, 32'hFF);
    bus_read("R5 e11", 8'h04);
    bus_write(8'h00, 32'd25);
    bus_write(8'h04, 32'h00);
    bus_read("R5 e25", 8'h04);

    // R6 merge entry
    bus_write(8'h00, 32'd12);
    bus_write(8'h04, 32'hFF);
    bus_read("R6", 8'h04);
    check("R6 value", exp_read(8'h04), 32'hCA);
    bus_write(8'h04, 32'hBF);
    bus_read("R6 clear", 8'h04);

    // R7 read-only slot
    bus_write(8'h08, 32'hFFFF_FFFF);
    bus_read("R7", 8'h08);

    // R8 control slot masking
    bus_write(8'h10, 32'hFFFF_FF7E);
    bus_read("R8", 8'h10);
    check("R8 value", exp_read(8'h10), 32'h7E);

    // R10 full-width slots
    bus_write(8'h3C, 32'hA5A5_5A5A);
    bus_read("R10", 8'h3C);
    bus_write(8'h0C, 32'h8000_0001);
    bus_read("R10", 8'h0C);

    // R9 soft reset via control slot
    bus_write(8'h00, 32'd12);
    bus_write(8'h04, 32'h40);
    bus_write(8'h18, 32'h1111_2222);
    bus_write(8'h00, 32'd9);
    bus_write(8'h04, 32'h99);
    bus_write(8'h10, 32'hFFFF_FF81);
    bus_read("R9 ctrl", 8'h10);
    check("R9 ctrl value", exp_read(8'h10), 32'h01);
    bus_read("R9 index", 8'h00);
    bus_read("R9 slot6", 8'h18);
    bus_write(8'h00, 32'd12);
    bus_read("R9 merge", 8'h04);
    bus_write(8'h00, 32'd9);
    bus_read("R9 entry9", 8'h04);

    // R11 read shows old value in the write cycle, new value after the edge
    bus_write(8'h20, 32'h0000_0001);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; addr = 8'h20; wdata = 32'h0000_0002;
    #1 check("R11 before edge", rdata, 32'h1);
    @(posedge clk);
    model_write(8'h20, 32'h2);
    #1 check("R11 after edge", rdata, 32'h2);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;

    // Random traffic, checked against the model (R2, R3, R10)
    for (int n = 0; n < 3000; n++) begin
      logic [7:0]  a;
      logic [31:0] d;
      int pick;
      pick = int'($urandom_range(0, 9));
      d = $urandom;
      a = 8'($urandom);
      if (pick < 3)      a = {a[7:6], 4'd0, a[1:0]};
      else if (pick < 6) a = {a[7:6], 4'd1, a[1:0]};
      if (a[5:2] == 4'd4 && $urandom_range(0, 15) != 0) d[0] = 1'b0;
      bus_write(a, d);
      bus_read("R10 random", 8'($urandom));
      bus_read("R3 random", {2'($urandom), 4'd1, 2'($urandom)});
    end

    // R1 hardware reset in mid-run
    hw_reset();
    check_reset_state("R1 rerun");

    done = 1;
    report();
  end
endmodule